// File: doc/BRIEF.md
# Dispatch Group Former

This block sits after instruction decode and packs a stream of instruction descriptors into dispatch groups of up to five slots. Each cycle it looks at one descriptor, presented with a valid/ready handshake, against the group being built. It returns one of three verdicts: accept the instruction into the current slot, close the group and retry in a fresh one (hazard), or place a no-op in the slot (no-op hazard). It also reports the current slot index and a strobe in the cycle a group closes.

Each descriptor carries a 5-bit flag word and an opcode tag. The flag word holds a unit class, a lead-only flag that requires slot 0, and a sole flag that requires slot 0 and then closes the group. Two tag values are parameters. One marks a write to the count register. The other marks a branch-and-link through that register. If the second follows the first within one group, the result is a no-op hazard. An advance input lets the surrounding pipeline close a group early. Address alias checks, microcoded instructions and cracked instructions are handled elsewhere.

Top module: `dispatch_group_former`

## Requirements
- R1: After a synchronous active-low reset, the slot index is 0, the verdict is idle, and in_ready and group_end are low until a descriptor or advance is presented.
- R2: A pseudo-class instruction (unit code 0) is always accepted, whatever its flags and slot, and does not move the slot index.
- R3: Fixed-point (1), load/store (2), floating-point (3), vector ALU (5) and vector permute (6) instructions are accepted in slots 0 to 3 and get a hazard in slot 4.
- R4: A condition-register instruction (unit code 4) is accepted only in slots 0 and 1. In any later slot it gets a hazard.
- R5: An instruction with the lead-only flag (flag bit 0) gets a hazard unless the slot index is 0. Once accepted, the group stays open for more instructions.
- R6: An instruction with the sole flag (flag bit 1) gets a hazard unless the slot index is 0. Once accepted, it raises group_end and the next slot index is 0.
- R7: A branch (unit code 7) is accepted in any slot, including slot 4. Its acceptance always raises group_end and returns the slot index to 0.
- R8: On a hazard, in_ready stays low and group_end is high. On the next cycle the same descriptor is evaluated against an empty group at slot 0.
- R9: After an instruction tagged TAG_CTR_WRITE is accepted, a branch tagged TAG_BR_CTR in the same group gets a no-op verdict with in_ready low. Each no-op takes a slot. The no-op that fills slot 4 closes the group, and the marker is cleared whenever a group closes.
- R10: While advance is high, no descriptor is taken, the verdict is idle, and the next slot index is 0. group_end is high only if the group held at least one slot.
- R11: The flag word carries the unit code in bits 4:2, the sole flag in bit 1 and the lead-only flag in bit 0. The verdict codes are 0 idle, 1 accept, 2 hazard and 3 no-op, and in_ready is high exactly on accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Descriptor present |
| in_flags | input | 5 | Unit code [4:2], sole [1], lead-only [0] |
| in_tag | input | TAG_W | Opcode tag used for the count-register rule |
| advance | input | 1 | Close the current group now |
| in_ready | output | 1 | Descriptor consumed this cycle |
| verdict | output | 2 | 0 idle, 1 accept, 2 hazard, 3 no-op |
| slot_idx | output | $clog2(SLOTS+1) | Slots already filled in the current group |
| group_end | output | 1 | The current group closes at this clock edge |

## Verification
The bench targets slot boundaries: a regular instruction arriving at slot 4, a condition-register instruction at slot 2, and lead-only and sole instructions arriving at slot 1. A design that gets one of these wrong either lets a non-branch into the branch-only slot or keeps a group open that should have closed. Each hazard case is followed by the retry cycle, so a design that drops the stalled descriptor or fails to clear its count leaves the retry in the wrong slot. The no-op chain checks that each no-op takes a slot and that the marker is cleared both at group close and on advance, so a sticky marker shows up as extra no-ops. A pseudo instruction carrying the lead-only flag at a non-zero slot catches a design that applies flag rules before class rules.

// File: rtl/dgf_pkg.sv
// Shared types for the dispatch group former.
// Assumes the 5-bit flag word layout {unit[2:0], sole, lead}.
package dgf_pkg;

    localparam int FLAG_W = 5;

    typedef enum logic [2:0] {
        UNIT_PSEUDO = 3'd0,
        UNIT_FIXED  = 3'd1,
        UNIT_LDST   = 3'd2,
        UNIT_FLOAT  = 3'd3,
        UNIT_CREG   = 3'd4,
        UNIT_VALU   = 3'd5,
        UNIT_VPERM  = 3'd6,
        UNIT_BRANCH = 3'd7
    } unit_e;

    typedef enum logic [1:0] {
        VERD_IDLE   = 2'd0,
        VERD_ACCEPT = 2'd1,
        VERD_HAZARD = 2'd2,
        VERD_NOOP   = 2'd3
    } verdict_e;

    // Packed view of the flag word; the field order fixes bit positions.
    typedef struct packed {
        unit_e unit;
        logic  sole;
        logic  lead;
    } flags_t;

endpackage

// File: rtl/dgf_decode.sv
// Descriptor decoder: splits the flag word and tag into the class
// signals used by the slot rules. Purely combinational.
// Assumes the tag values for a count-register write and a branch-and-link
// through that register are fixed at build time.
module dgf_decode
    import dgf_pkg::*;
#(
    parameter int                TAG_W        = 8,
    parameter logic [TAG_W-1:0]  TAG_CTR_WRITE = 8'h2A,
    parameter logic [TAG_W-1:0]  TAG_BR_CTR    = 8'h4E
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic [TAG_W-1:0]  tag,
    output logic              is_pseudo,
    output logic              is_branch,
    output logic              is_creg,
    output logic              is_regular,
    output logic              needs_lead,
    output logic              is_sole,
    output logic              is_ctr_write,
    output logic              is_br_ctr
);

    flags_t fw;

    // Reinterpret the raw flag word through the packed struct.
    always_comb fw = flags_t'(flags);

    // Map the unit code onto slot classes.
    always_comb begin
        is_pseudo  = (fw.unit == UNIT_PSEUDO);
        is_branch  = (fw.unit == UNIT_BRANCH);
        is_creg    = (fw.unit == UNIT_CREG);
        is_regular = 1'b0;
        case (fw.unit)
            UNIT_FIXED, UNIT_LDST, UNIT_FLOAT,
            UNIT_VALU, UNIT_VPERM: is_regular = 1'b1;
            default:               is_regular = 1'b0;
        endcase
    end

    // Placement flags and the count-register tag matches.
    always_comb begin
        needs_lead   = fw.lead | fw.sole;
        is_sole      = fw.sole;
        is_ctr_write = (tag == TAG_CTR_WRITE);
        is_br_ctr    = (tag == TAG_BR_CTR) && (fw.unit == UNIT_BRANCH);
    end

endmodule

// File: rtl/dgf_rules.sv
// Slot rules: turns the decoded descriptor and the current group state
// into a verdict and the next group state. Purely combinational.
// Assumes the issued count never exceeds SLOTS-1 between cycles.
module dgf_rules
    import dgf_pkg::*;
#(
    parameter int SLOTS    = 5,
    parameter int CR_SLOTS = 2,
    localparam int CNT_W   = $clog2(SLOTS + 1)
) (
    input  logic             in_valid,
    input  logic             advance,
    input  logic             is_pseudo,
    input  logic             is_branch,
    input  logic             is_creg,
    input  logic             is_regular,
    input  logic             needs_lead,
    input  logic             is_sole,
    input  logic             is_ctr_write,
    input  logic             is_br_ctr,
    input  logic [CNT_W-1:0] issued,
    input  logic             ctr_mark,
    output verdict_e         verdict,
    output logic             close,
    output logic [CNT_W-1:0] issued_nx,
    output logic             ctr_mark_nx
);

    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);
    localparam logic [CNT_W-1:0] FULL      = CNT_W'(SLOTS);
    localparam logic [CNT_W-1:0] CR_LIMIT  = CNT_W'(CR_SLOTS);

    logic             lead_block;
    logic             class_block;
    logic             noop_hit;
    logic [CNT_W-1:0] bump;

    // Hazard and no-op conditions in priority order.
    always_comb begin
        lead_block  = needs_lead && (issued != '0);
        class_block = ((is_regular || is_creg) && (issued >= LAST_SLOT))
                    || (is_creg && (issued >= CR_LIMIT));
        noop_hit    = is_br_ctr && ctr_mark;
    end

    // Verdict selection.
    always_comb begin
        if (!in_valid || advance)          verdict = VERD_IDLE;
        else if (is_pseudo)                verdict = VERD_ACCEPT;
        else if (lead_block || class_block) verdict = VERD_HAZARD;
        else if (noop_hit)                 verdict = VERD_NOOP;
        else                               verdict = VERD_ACCEPT;
    end

    // Slot count after this cycle: a branch or sole instruction fills the group.
    always_comb begin
        if ((verdict == VERD_ACCEPT) && (is_branch || is_sole))
            bump = FULL;
        else
            bump = issued + CNT_W'(1);
    end

    // Next group state and the group-close strobe.
    always_comb begin
        close       = 1'b0;
        issued_nx   = issued;
        ctr_mark_nx = ctr_mark;
        if (advance) begin
            close       = (issued != '0);
            issued_nx   = '0;
            ctr_mark_nx = 1'b0;
        end else if (verdict == VERD_HAZARD) begin
            close       = 1'b1;
            issued_nx   = '0;
            ctr_mark_nx = 1'b0;
        end else if ((verdict == VERD_NOOP) ||
                     ((verdict == VERD_ACCEPT) && !is_pseudo)) begin
            if (bump >= FULL) begin
                close       = 1'b1;
                issued_nx   = '0;
                ctr_mark_nx = 1'b0;
            end else begin
                issued_nx   = bump;
                ctr_mark_nx = ctr_mark ||
                              ((verdict == VERD_ACCEPT) && is_ctr_write);
            end
        end
    end

endmodule

// File: rtl/dgf_tracker.sv
// Group state registers: issued slot count and count-register marker.
// Assumes the synchronous active-low reset starts an empty group.
module dgf_tracker #(
    parameter int SLOTS  = 5,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] issued_nx,
    input  logic             ctr_mark_nx,
    output logic [CNT_W-1:0] issued,
    output logic             ctr_mark
);

    // Register the next group state each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued   <= '0;
            ctr_mark <= 1'b0;
        end else begin
            issued   <= issued_nx;
            ctr_mark <= ctr_mark_nx;
        end
    end

endmodule

// File: rtl/dispatch_group_former.sv
// Dispatch group former top: decodes each descriptor, applies the slot
// rules against the group in progress and keeps the group state.
// Assumes the producer holds a descriptor steady until in_ready is high.
module dispatch_group_former
    import dgf_pkg::*;
#(
    parameter int               SLOTS         = 5,
    parameter int               CR_SLOTS      = 2,
    parameter int               TAG_W         = 8,
    parameter logic [TAG_W-1:0] TAG_CTR_WRITE = 8'h2A,
    parameter logic [TAG_W-1:0] TAG_BR_CTR    = 8'h4E
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [4:0]                   in_flags,
    input  logic [TAG_W-1:0]             in_tag,
    input  logic                         advance,
    output logic                         in_ready,
    output logic [1:0]                   verdict,
    output logic [$clog2(SLOTS+1)-1:0]   slot_idx,
    output logic                         group_end
);

    localparam int CNT_W = $clog2(SLOTS + 1);

    logic             is_pseudo, is_branch, is_creg, is_regular;
    logic             needs_lead, is_sole, is_ctr_write, is_br_ctr;
    logic [CNT_W-1:0] issued, issued_nx;
    logic             ctr_mark, ctr_mark_nx;
    logic             close;
    verdict_e         verd;

    dgf_decode #(
        .TAG_W         (TAG_W),
        .TAG_CTR_WRITE (TAG_CTR_WRITE),
        .TAG_BR_CTR    (TAG_BR_CTR)
    ) decode_i (
        .flags        (in_flags),
        .tag          (in_tag),
        .is_pseudo    (is_pseudo),
        .is_branch    (is_branch),
        .is_creg      (is_creg),
        .is_regular   (is_regular),
        .needs_lead   (needs_lead),
        .is_sole      (is_sole),
        .is_ctr_write (is_ctr_write),
        .is_br_ctr    (is_br_ctr)
    );

    dgf_rules #(
        .SLOTS    (SLOTS),
        .CR_SLOTS (CR_SLOTS)
    ) rules_i (
        .in_valid     (in_valid),
        .advance      (advance),
        .is_pseudo    (is_pseudo),
        .is_branch    (is_branch),
        .is_creg      (is_creg),
        .is_regular   (is_regular),
        .needs_lead   (needs_lead),
        .is_sole      (is_sole),
        .is_ctr_write (is_ctr_write),
        .is_br_ctr    (is_br_ctr),
        .issued       (issued),
        .ctr_mark     (ctr_mark),
        .verdict      (verd),
        .close        (close),
        .issued_nx    (issued_nx),
        .ctr_mark_nx  (ctr_mark_nx)
    );

    dgf_tracker #(
        .SLOTS (SLOTS)
    ) tracker_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .issued_nx   (issued_nx),
        .ctr_mark_nx (ctr_mark_nx),
        .issued      (issued),
        .ctr_mark    (ctr_mark)
    );

    // Drive the output ports from the rule and state signals.
    always_comb begin
        verdict   = verd;
        in_ready  = (verd == VERD_ACCEPT);
        slot_idx  = issued;
        group_end = close;
    end

endmodule

// File: rtl/dgf_checker.sv
// Property checker for the dispatch group former, bound to the top.
// Assumes rst_n is held low from time zero until the first clean cycle.
module dgf_checker #(
    parameter int SLOTS    = 5,
    parameter int CR_SLOTS = 2,
    localparam int CNT_W   = $clog2(SLOTS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [4:0]       in_flags,
    input logic             advance,
    input logic             in_ready,
    input logic [1:0]       verdict,
    input logic [CNT_W-1:0] slot_idx,
    input logic             group_end
);

    logic [2:0] unit;
    always_comb unit = in_flags[4:2];

    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        slot_idx < CNT_W'(SLOTS)); // R7
    AST_PSEUDO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !advance && unit == 3'd0) |-> in_ready); // R2
    AST_PSEUDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && unit == 3'd0) |=> $stable(slot_idx)); // R2
    AST_LAST_SLOT_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && slot_idx == CNT_W'(SLOTS - 1) && unit != 3'd0) |-> unit == 3'd7); // R3
    AST_CREG_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && unit == 3'd4) |-> slot_idx < CNT_W'(CR_SLOTS)); // R4
    AST_LEAD_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && unit != 3'd0 && in_flags[1:0] != 2'b00) |-> slot_idx == '0); // R5
    AST_SOLE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && unit != 3'd0 && in_flags[1]) |-> group_end); // R6
    AST_BRANCH_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && unit == 3'd7) |=> slot_idx == '0); // R7
    AST_HAZARD_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict == 2'd2) |=> slot_idx == '0); // R8
    AST_HAZARD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict == 2'd2) |-> (!in_ready && group_end)); // R8
    AST_NOOP_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict == 2'd3) |-> (unit == 3'd7 && !in_ready)); // R9
    AST_ADVANCE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> slot_idx == '0); // R10
    AST_ADVANCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (verdict == 2'd0 && !in_ready)); // R10

endmodule

bind dispatch_group_former dgf_checker #(
    .SLOTS    (SLOTS),
    .CR_SLOTS (CR_SLOTS)
) checker_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_flags  (in_flags),
    .advance   (advance),
    .in_ready  (in_ready),
    .verdict   (verdict),
    .slot_idx  (slot_idx),
    .group_end (group_end)
);

// File: tb/dispatch_group_former_tb_top.sv
// Directed bench for the dispatch group former: one task per scenario.
module dispatch_group_former_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] T_PLAIN = 8'h01;
    localparam logic [7:0] T_CTRW  = 8'h2A;
    localparam logic [7:0] T_BRCTR = 8'h4E;
    localparam logic [2:0] U_PS = 3'd0, U_FX = 3'd1, U_LS = 3'd2, U_FP = 3'd3,
                           U_CR = 3'd4, U_VA = 3'd5, U_VP = 3'd6, U_BR = 3'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [4:0] in_flags = '0;
    logic [7:0] in_tag = '0;
    logic       advance = 1'b0;
    logic       in_ready;
    logic [1:0] verdict;
    logic [2:0] slot_idx;
    logic       group_end;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dispatch_group_former dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_flags  (in_flags),
        .in_tag    (in_tag),
        .advance   (advance),
        .in_ready  (in_ready),
        .verdict   (verdict),
        .slot_idx  (slot_idx),
        .group_end (group_end)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [4:0] fl(input logic [2:0] u, input logic sole, input logic lead);
        return {u, sole, lead};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Present inputs after a falling edge, sample before the next rising edge.
    task automatic step(input string req, input logic v, input logic [4:0] f,
                        input logic [7:0] t, input logic a,
                        input int e_verd, input int e_rdy, input int e_slot, input int e_end);
        in_valid = v; in_flags = f; in_tag = t; advance = a;
        #(CLK_PERIOD/4);
        chk(req, "verdict",   int'(verdict),   e_verd);
        chk(req, "in_ready",  int'(in_ready),  e_rdy);
        chk(req, "slot_idx",  int'(slot_idx),  e_slot);
        chk(req, "group_end", int'(group_end), e_end);
        @(negedge clk);
        in_valid = 1'b0; advance = 1'b0;
    endtask

    task automatic flush();
        step("R10", 1'b0, '0, T_PLAIN, 1'b1, 0, 0, -1 < 0 ? int'(slot_idx) : 0, int'(slot_idx != 0));
    endtask

    task automatic t_reset();
        #(CLK_PERIOD/4);
        chk("R1", "slot_idx", int'(slot_idx), 0);
        chk("R1", "verdict", int'(verdict), 0);
        chk("R1", "in_ready", int'(in_ready), 0);
        chk("R1", "group_end", int'(group_end), 0);
        @(negedge clk);
    endtask

    // R3/R8/R11: four regulars, hazard at slot 4, retry in a fresh group.
    task automatic t_regular();
        step("R3", 1, fl(U_FX,0,0), T_PLAIN, 0, 1, 1, 0, 0);
        step("R3", 1, fl(U_LS,0,0), T_PLAIN, 0, 1, 1, 1, 0);
        step("R3", 1, fl(U_FP,0,0), T_PLAIN, 0, 1, 1, 2, 0);
        step("R11", 1, fl(U_VA,0,0), T_PLAIN, 0, 1, 1, 3, 0);
        step("R3", 1, fl(U_VP,0,0), T_PLAIN, 0, 2, 0, 4, 1);
        step("R8", 1, fl(U_VP,0,0), T_PLAIN, 0, 1, 1, 0, 0);
        step("R10", 0, '0, T_PLAIN, 1, 0, 0, 1, 1);
        step("R10", 0, '0, T_PLAIN, 1, 0, 0, 0, 0);
    endtask

    // R2: pseudo never consumes a slot, even with lead flag at slot 1.
    task automatic t_pseudo();
        step("R2", 1, fl(U_PS,0,0), T_PLAIN, 0, 1, 1, 0, 0);
        step("R2", 1, fl(U_FX,0,0), T_PLAIN, 0, 1, 1, 0, 0);
        step("R2", 1, fl(U_PS,1,1), T_PLAIN, 0, 1, 1, 1, 0);
        step("R2", 0, '0, T_PLAIN, 1, 0, 0, 1, 1);
    endtask

    // R4: condition-register ops only in slots 0 and 1.
    task automatic t_creg();
        step("R4", 1, fl(U_CR,0,0), T_PLAIN, 0, 1, 1, 0, 0);
        step("R4", 1, fl(U_CR,0,0), T_PLAIN, 0, 1, 1, 1, 0);
        step("R4", 1, fl(U_CR,0,0), T_PLAIN, 0, 2, 0, 2, 1);
        step("R8", 1, fl(U_CR,0,0), T_PLAIN, 0, 1, 1, 0, 0);
        step("R4", 0, '0, T_PLAIN, 1, 0, 0, 1, 1);
    endtask

    // R5: lead-only flag needs slot 0 and leaves the group open.
    task automatic t_lead();
        step("R5", 1, fl(U_FX,0,0), T_PLAIN, 0, 1, 1, 0, 0);
        step("R5", 1, fl(U_FX,0,1), T_PLAIN, 0, 2, 0, 1, 1);
        step("R5", 1, fl(U_FX,0,1), T_PLAIN, 0, 1, 1, 0, 0);
        step("R5", 1, fl(U_LS,0,0), T_PLAIN, 0, 1, 1, 1, 0);
        step("R5", 0, '0, T_PLAIN, 1, 0, 0, 2, 1);
    endtask

    // R6: sole flag needs slot 0 and closes the group.
    task automatic t_sole();
        step("R6", 1, fl(U_FX,1,0), T_PLAIN, 0, 1, 1, 0, 1);
        step("R6", 1, fl(U_FP,0,0), T_PLAIN, 0, 1, 1, 0, 0);
        step("R6", 1, fl(U_FX,1,0), T_PLAIN, 0, 2, 0, 1, 1);
        step("R6", 1, fl(U_FX,1,0), T_PLAIN, 0, 1, 1, 0, 1);
        step("R6", 0, '0, T_PLAIN, 0, 0, 0, 0, 0);
    endtask

    // R7: branch fits slot 4 and slot 1, and always closes.
    task automatic t_branch();
        step("R7", 1, fl(U_FX,0,0), T_PLAIN, 0, 1, 1, 0, 0);
        step("R7", 1, fl(U_FX,0,0), T_PLAIN, 0, 1, 1, 1, 0);
        step("R7", 1, fl(U_FX,0,0), T_PLAIN, 0, 1, 1, 2, 0);
        step("R7", 1, fl(U_FX,0,0), T_PLAIN, 0, 1, 1, 3, 0);
        step("R7", 1, fl(U_BR,0,0), T_PLAIN, 0, 1, 1, 4, 1);
        step("R7", 1, fl(U_LS,0,0), T_PLAIN, 0, 1, 1, 0, 0);
        step("R7", 1, fl(U_BR,0,0), T_PLAIN, 0, 1, 1, 1, 1);
        step("R7", 0, '0, T_PLAIN, 0, 0, 0, 0, 0);
    endtask

    // R9: no-op chain after a count-register write, and marker clearing.
    task automatic t_noop();
        step("R9", 1, fl(U_BR,0,0), T_BRCTR, 0, 1, 1, 0, 1);
        step("R9", 1, fl(U_FX,0,0), T_CTRW,  0, 1, 1, 0, 0);
        step("R9", 1, fl(U_BR,0,0), T_BRCTR, 0, 3, 0, 1, 0);
        step("R9", 1, fl(U_BR,0,0), T_BRCTR, 0, 3, 0, 2, 0);
        step("R9", 1, fl(U_BR,0,0), T_BRCTR, 0, 3, 0, 3, 0);
        step("R9", 1, fl(U_BR,0,0), T_BRCTR, 0, 3, 0, 4, 1);
        step("R9", 1, fl(U_BR,0,0), T_BRCTR, 0, 1, 1, 0, 1);
        step("R9", 1, fl(U_FX,0,0), T_CTRW,  0, 1, 1, 0, 0);
        step("R10", 0, '0, T_PLAIN, 1, 0, 0, 1, 1);
        step("R9", 1, fl(U_BR,0,0), T_BRCTR, 0, 1, 1, 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regular();
        t_pseudo();
        t_creg();
        t_lead();
        t_sole();
        t_branch();
        t_noop();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule